// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of an on-chip scratchpad split into 16 interleaved banks. Every bank serves one 32-bit word per clock. Each cycle the block can take one request vector from a group of 16 lanes. Every lane carries an active flag, a write flag, a word address and write data. The block finds the bank of each lane's address and sorts the active lanes into rounds that do not conflict. It then runs one round per cycle until every active lane has been served.

Lanes that hit one bank at the same word are served together, so a word requested by every lane costs a single cycle. Lanes that hit one bank at different words are taken in turn. The number of cycles a vector needs is therefore the largest count of distinct words requested in any one bank. While a vector is in progress the block holds its stall output high. In the cycle a lane is served, that lane's done bit pulses and, for a read, its read data is valid.

Top module: `spad_conflict_serializer`

## Requirements
- R1: The bank of a request is the word address modulo 16, which is the low 4 address bits. The row inside the bank is given by the remaining upper address bits.
- R2: When every active lane targets a different bank, in linear order or in any permutation, the whole vector is served in one cycle.
- R3: When all active lanes request the identical word, the vector takes one cycle and every lane receives the same word.
- R4: A vector takes exactly as many cycles as the largest number of distinct words requested in any single bank. For example, a stride-2 read pattern takes 2 cycles, a stride-8 pattern takes 8 and a stride-16 pattern takes 16. No cycle serves two different words of one bank.
- R5: All pending lanes that request the same word of a bank are served in the same round.
- R6: In each round, every bank serves the word requested by its lowest-numbered lane that is still pending. A lane is therefore served in the round equal to the number of distinct words in its bank whose first requesting lane has a lower index than the first requester of its own word.
- R7: A lane whose active bit is low never gets a done pulse, never writes, and adds no cycles to the vector.
- R8: Stall is low after reset. A vector is accepted on a clock edge where req_valid is high and stall is low. Stall is then high from the next cycle through the cycle of the final round, and falls after that. A vector with no active lanes never raises stall.
- R9: Each active lane receives exactly one done pulse, in the cycle it is served. A reading lane's rdata in that cycle is the word's value from before the vector was accepted.
- R10: Writes take effect once the vector is done. When several lanes write the same word, the highest-numbered writer's data is kept, and lanes reading that word in the same round see the old value.
- R11: A req_valid asserted while stall is high is ignored. It neither starts a new vector nor changes memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Offers a request vector; taken when stall is low |
| lane_act | input | 16 | Per-lane active flag |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | 16 x 8 | Per-lane word address |
| lane_wdata | input | 16 x 32 | Per-lane write data |
| stall | output | 1 | High while a vector is being served |
| done | output | 16 | Per-lane pulse in the cycle the lane is served |
| rdata | output | 16 x 32 | Per-lane read word, valid with done |

## Verification
The bench uses a mixed vector in which one bank receives a repeated word interleaved with two other words. A design that picks the served address by anything other than the lowest pending lane serves those lanes in the wrong rounds, and one that does not merge equal addresses takes an extra cycle. Stride-2, stride-8 and stride-16 patterns expose a round count that is off by one or that treats a broadcast as a conflict. A vector with several lanes writing one word catches a write-priority mistake and reads that see the new data too early. A request held during stall, inactive lanes carrying write flags, and an all-inactive vector show whether the design takes work it should ignore: that would corrupt memory, produce stray done pulses or raise stall.

// File: rtl/spad_pkg.sv
package spad_pkg;
    localparam int LANES = 16;
    localparam int BANKS = 16;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int BW    = $clog2(BANKS);
    localparam int RW    = AW - BW;
    localparam int ROWS  = 1 << RW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } lane_req_t;

    typedef struct packed {
        logic          en;
        logic [RW-1:0] row;
        logic [DW-1:0] data;
    } bank_wr_t;

    function automatic logic [BW-1:0] bank_of(input logic [AW-1:0] a);
        return a[BW-1:0];
    endfunction

    function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
        return a[AW-1:BW];
    endfunction
endpackage

// File: rtl/spad_bank_pick.sv
module spad_bank_pick
    import spad_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]            pend,
    input  lane_req_t [LANES-1:0]       req,
    output logic [LANES-1:0]            serve,
    output bank_wr_t                    wr,
    output logic [RW-1:0]               rd_row
);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic          found;
    logic [AW-1:0] lead;

    // leader: lowest-numbered pending lane mapped to this bank
    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pend[l] && bank_of(req[l].addr) == MY_BANK) begin
                found = 1'b1;
                lead  = req[l].addr;
            end
        end
    end

    // all pending lanes on the leader's word ride along; last writer wins
    always_comb begin
        serve   = '0;
        wr.en   = 1'b0;
        wr.data = '0;
        wr.row  = row_of(lead);
        for (int l = 0; l < LANES; l++) begin
            if (found && pend[l] && req[l].addr == lead) begin
                serve[l] = 1'b1;
                if (req[l].we) begin
                    wr.en   = 1'b1;
                    wr.data = req[l].wdata;
                end
            end
        end
    end

    assign rd_row = row_of(lead);
endmodule

// File: rtl/spad_bank.sv
module spad_bank
    import spad_pkg::*;
(
    input  logic          clk,
    input  bank_wr_t      wr,
    input  logic [RW-1:0] rd_row,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr.en) begin
            mem[wr.row] <= wr.data;
        end
    end

    assign rd_data = mem[rd_row];
endmodule

// File: rtl/spad_conflict_serializer.sv
module spad_conflict_serializer
    import spad_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [LANES-1:0]           lane_act,
    input  logic [LANES-1:0]           lane_we,
    input  logic [LANES-1:0][AW-1:0]   lane_addr,
    input  logic [LANES-1:0][DW-1:0]   lane_wdata,
    output logic                       stall,
    output logic [LANES-1:0]           done,
    output logic [LANES-1:0][DW-1:0]   rdata
);
    logic [LANES-1:0]      pend_q;
    lane_req_t [LANES-1:0] req_q;
    logic [LANES-1:0]      serve_b [BANKS];
    bank_wr_t              wr_b    [BANKS];
    logic [RW-1:0]         row_b   [BANKS];
    logic [DW-1:0]         word_b  [BANKS];
    logic [LANES-1:0]      serve_all;
    logic                  busy;
    logic                  accept;

    assign busy   = |pend_q;
    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            req_q  <= '0;
        end else if (accept) begin
            pend_q <= lane_act;
            for (int l = 0; l < LANES; l++) begin
                req_q[l].we    <= lane_we[l];
                req_q[l].addr  <= lane_addr[l];
                req_q[l].wdata <= lane_wdata[l];
            end
        end else begin
            pend_q <= pend_q & ~serve_all;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spad_bank_pick #(.BANK_ID(b)) u_pick (
            .pend   (pend_q),
            .req    (req_q),
            .serve  (serve_b[b]),
            .wr     (wr_b[b]),
            .rd_row (row_b[b])
        );
        spad_bank u_bank (
            .clk     (clk),
            .wr      (wr_b[b]),
            .rd_row  (row_b[b]),
            .rd_data (word_b[b])
        );
    end

    always_comb begin
        serve_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            serve_all = serve_all | serve_b[b];
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rdata[l] = word_b[bank_of(req_q[l].addr)];
        end
    end

    assign done  = serve_all;
    assign stall = busy;
endmodule

// File: rtl/spad_conflict_serializer_chk.sv
module spad_conflict_serializer_chk
    import spad_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic [LANES-1:0]         lane_act,
    input logic [LANES-1:0][AW-1:0] lane_addr,
    input logic                     stall,
    input logic [LANES-1:0]         done
);
    logic [LANES-1:0]         act_q;
    logic [LANES-1:0]         served_q;
    logic [LANES-1:0][AW-1:0] addr_q;
    logic                     clash;
    logic                     split_grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            addr_q   <= '0;
            served_q <= '0;
        end else begin
            if (req_valid && !stall) begin
                act_q  <= lane_act;
                addr_q <= lane_addr;
            end
            served_q <= stall ? (served_q | done) : '0;
        end
    end

    always_comb begin
        clash     = 1'b0;
        split_grp = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (i != j && done[i] && done[j] &&
                    bank_of(addr_q[i]) == bank_of(addr_q[j]) && addr_q[i] != addr_q[j])
                    clash = 1'b1;
                if (i != j && done[i] && act_q[j] && !served_q[j] && !done[j] &&
                    addr_q[i] == addr_q[j])
                    split_grp = 1'b1;
            end
        end
    end

    AST_DONE_IN_STALL: assert property (@(posedge clk) disable iff (rst) (|done) |-> stall); // R9
    AST_ROUND_PROGRESS: assert property (@(posedge clk) disable iff (rst) stall |-> (|done)); // R4
    AST_SERVED_ONCE: assert property (@(posedge clk) disable iff (rst) stall |-> ((done & served_q) == '0)); // R9
    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst) stall |-> ((done & ~act_q) == '0)); // R7
    AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (rst) stall |-> !clash); // R4
    AST_GROUP_TOGETHER: assert property (@(posedge clk) disable iff (rst) stall |-> !split_grp); // R5
    AST_STALL_END: assert property (@(posedge clk) disable iff (rst) (stall && ((served_q | done) == act_q)) |=> !stall); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) (stall && ((served_q | done) != act_q)) |=> stall); // R8
    AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (rst) (req_valid && !stall && lane_act == '0) |=> !stall); // R8
endmodule

bind spad_conflict_serializer spad_conflict_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .lane_act  (lane_act),
    .lane_addr (lane_addr),
    .stall     (stall),
    .done      (done)
);

// File: tb/spad_conflict_serializer_bench.sv
module spad_conflict_serializer_bench;
    import spad_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic [LANES-1:0]         lane_act = '0;
    logic [LANES-1:0]         lane_we = '0;
    logic [LANES-1:0][AW-1:0] lane_addr = '0;
    logic [LANES-1:0][DW-1:0] lane_wdata = '0;
    logic                     stall;
    logic [LANES-1:0]         done;
    logic [LANES-1:0][DW-1:0] rdata;

    logic [LANES-1:0]         v_act;
    logic [LANES-1:0]         v_we;
    logic [LANES-1:0][AW-1:0] v_addr;
    logic [LANES-1:0][DW-1:0] v_wd;
    logic [DW-1:0]            model [1 << AW];

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spad_conflict_serializer u_spad_conflict_serializer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .lane_act(lane_act),
        .lane_we(lane_we), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .stall(stall), .done(done), .rdata(rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(32'h5A00_0000 ^ (a * 32'h0101_0137) ^ (salt << 20));
    endfunction

    // caller is at a negedge; applies v_* and checks every round
    task automatic run_vec(input string tag, input bit inject);
        int            first [LANES];
        int            exp_rnd [LANES];
        int            got [LANES];
        logic [DW-1:0] old [LANES];
        int            deg = 0;
        int            cyc = 0;
        for (int l = 0; l < LANES; l++) begin
            first[l] = l;
            for (int j = 0; j < l; j++)
                if (first[l] == l && v_act[j] && v_act[l] && v_addr[j] == v_addr[l])
                    first[l] = j;
        end
        for (int l = 0; l < LANES; l++) begin
            int cnt = 0;
            got[l] = 0;
            old[l] = model[v_addr[l]];
            exp_rnd[l] = -1;
            if (v_act[l]) begin
                for (int j = 0; j < LANES; j++)
                    if (v_act[j] && first[j] == j && j < first[l] &&
                        bank_of(v_addr[j]) == bank_of(v_addr[l]) && v_addr[j] != v_addr[l])
                        cnt++;
                exp_rnd[l] = cnt;
                if (cnt + 1 > deg) deg = cnt + 1;
            end
        end
        req_valid = 1'b1; lane_act = v_act; lane_we = v_we;
        lane_addr = v_addr; lane_wdata = v_wd;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; lane_act = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
        while (stall && cyc < LANES + 4) begin
            if (inject && cyc == 0) begin
                req_valid = 1'b1; lane_act = '1; lane_we = '1;
                for (int l = 0; l < LANES; l++) begin
                    lane_addr[l] = AW'(l);
                    lane_wdata[l] = 32'hDEAD_0000 + DW'(l);
                end
            end
            if (inject && cyc == deg - 1) req_valid = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (done[l]) begin
                    got[l]++;
                    check(exp_rnd[l] == cyc, tag, $sformatf("R6 lane %0d round", l), cyc, exp_rnd[l]);
                    if (!v_we[l])
                        check(rdata[l] == old[l], tag, $sformatf("R9 lane %0d rdata", l), rdata[l], old[l]);
                end
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0; lane_act = '0; lane_we = '0;
        check(cyc == deg, tag, "R4 stall cycles", cyc, deg);
        for (int l = 0; l < LANES; l++)
            check(got[l] == (v_act[l] ? 1 : 0), tag, $sformatf("R9 R7 lane %0d done count", l),
                  got[l], v_act[l] ? 1 : 0);
        for (int l = 0; l < LANES; l++)
            if (v_act[l] && v_we[l]) model[v_addr[l]] = v_wd[l];
    endtask

    task automatic read_all(input string tag);
        for (int v = 0; v < (1 << AW) / LANES; v++) begin
            v_act = '1; v_we = '0; v_wd = '0;
            for (int l = 0; l < LANES; l++) v_addr[l] = AW'(v * LANES + l);
            run_vec(tag, 1'b0);
        end
    endtask

    task automatic t_reset();
        check(stall == 1'b0, "R8", "stall after reset", stall, 0);
        check(done == '0, "R8", "done after reset", done, 0);
    endtask

    task automatic t_fill();
        for (int v = 0; v < (1 << AW) / LANES; v++) begin
            v_act = '1; v_we = '1;
            for (int l = 0; l < LANES; l++) begin
                v_addr[l] = AW'(v * LANES + l);
                v_wd[l] = pat(v * LANES + l, 1);
            end
            run_vec("R2 R1 fill", 1'b0);
        end
        read_all("R1 readback");
    endtask

    task automatic t_permute();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(32 + ((l * 5 + 3) % 16));
        run_vec("R2 permutation", 1'b0);
    endtask

    task automatic t_broadcast();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(77);
        run_vec("R3 broadcast", 1'b0);
    endtask

    task automatic t_strides();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(l * 2);
        run_vec("R4 stride2", 1'b0);
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(l * 8 + 1);
        run_vec("R4 stride8", 1'b0);
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(l * 16 + 5);
        run_vec("R4 stride16", 1'b0);
    endtask

    task automatic t_order();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(128 + l);
        v_addr[0] = 8'd32; v_addr[1] = 8'd16; v_addr[2] = 8'd32; v_addr[3] = 8'd0;
        v_addr[4] = 8'd16;
        run_vec("R5 R6 mixed order", 1'b0);
    endtask

    task automatic t_inactive();
        v_act = '0; v_we = '1;
        for (int l = 0; l < LANES; l++) begin
            v_addr[l] = AW'(l * 8);
            v_wd[l] = pat(l, 9);
        end
        v_act[0] = 1'b1; v_act[1] = 1'b1;
        run_vec("R7 sparse", 1'b0);
        v_act = '0;
        run_vec("R7 R8 empty", 1'b0);
        read_all("R7 memory untouched");
    endtask

    task automatic t_same_writers();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(192 + l);
        v_addr[3] = 8'd50; v_addr[5] = 8'd50; v_addr[7] = 8'd50; v_addr[9] = 8'd50;
        v_we[3] = 1'b1; v_we[7] = 1'b1; v_we[9] = 1'b1;
        v_wd[3] = 32'h1111_0003; v_wd[7] = 32'h1111_0007; v_wd[9] = 32'h1111_0009;
        run_vec("R10 shared writers", 1'b0);
        v_act = '1; v_we = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(50);
        run_vec("R10 readback", 1'b0);
    endtask

    task automatic t_busy_ignore();
        v_act = '1; v_we = '0; v_wd = '0;
        for (int l = 0; l < LANES; l++) v_addr[l] = AW'(l * 8 + 2);
        run_vec("R11 held request", 1'b1);
        check(stall == 1'b0, "R11", "stall after held request", stall, 0);
        read_all("R11 memory untouched");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_permute();
        t_broadcast();
        t_strides();
        t_order();
        t_inactive();
        t_same_writers();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule